// File: doc/BRIEF.md
# Software-Loaded TLB Register Front End

This block holds the support registers that system software uses to read and load entries of a software-managed translation buffer. Software picks one of four register banks with a 2-bit bank number taken from the low bits of a wider bank-select value. Each bank has four 32-bit registers: a fault-cause register, an entry-select register, and HI and LO mirror registers. Banks 1 and 2 are the two MMU banks. Each one owns its own store of entries, organised as 4 sets of 16 ways. Banks 0 and 3 are plain register banks with no side effects.

In an MMU bank, a write to HI also loads the cause register. A write to LO commits an entry. Its LO half is the written value and its HI half is the current cause register. The target slot comes from the select register. Any read in an MMU bank first refreshes the HI and LO mirrors from the selected entry, then returns the requested register. Every commit sends out a one-cycle invalidate request. The request carries the page address of the entry being overwritten and that entry's old valid bit, so the translation cache can drop the stale page.

Top module: `tlbf_front`

## Requirements
- R1: After reset, every register in every bank reads zero, every stored entry is zero (invalid), `acc_rdata` is zero and `flush_valid` is low.
- R2: The bank number is `bank_sel[1:0]`. Higher bits of `bank_sel` are ignored, so a value of 5 reaches bank 1 and a value of 7 reaches bank 3.
- R3: In bank 1 or 2, writing HI (register code 2) also writes the same value into the cause register (code 0) of that bank.
- R4: In bank 1 or 2, writing LO (code 3) stores {HI = that bank's cause register, LO = written value} into the entry selected by the select register (code 1). Select bits [5:4] give the set and bits [3:0] give the way.
- R5: In bank 1 or 2, a read first copies the selected entry into the HI and LO mirrors. A read of HI or LO therefore returns the stored entry, not a value written to HI earlier.
- R6: Every commit sets `flush_valid` for exactly the cycle after the write. `flush_addr` is the old entry's HI with bits [11:0] cleared, and `flush_old_valid` is bit 0 of the old entry's LO.
- R7: Banks 1 and 2 keep separate entry stores. A commit in one bank is not visible through the same select value in the other bank.
- R8: In banks 0 and 3, all four registers are plain storage. Writing HI does not touch the cause register, writing LO commits nothing and raises no flush, and reads return the stored values.
- R9: Read data appears on `acc_rdata` one cycle after the read request and holds until the next read. Writes and idle cycles leave it unchanged.
- R10: `flush_valid` stays low after reads, after writes to registers other than LO, and after idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 32 | Bank-select value; only bits [1:0] are used |
| acc_en | input | 1 | Register access request this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_reg | input | 2 | Register code: 0 cause, 1 select, 2 HI, 3 LO |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Registered read data |
| flush_valid | output | 1 | One-cycle invalidate request |
| flush_addr | output | 32 | Page address of the overwritten entry |
| flush_old_valid | output | 1 | Valid bit of the overwritten entry |

## Verification
Each result is registered once. Read data, mirror updates, entry commits and the invalidate pulse are all due one clock edge after the request. The bench drives every request on a falling edge and samples the outputs on the next falling edge. This is exactly one rising edge later, so each vector is checked in the cycle its result becomes due. The invalidate outputs are checked after every vector, so a missing pulse is caught, and so is a pulse that appears where none is due. The holding behaviour of `acc_rdata` is checked after later writes and after idle cycles.

// File: rtl/tlbf_pkg.sv
package tlbf_pkg;
    localparam int DW     = 32;
    localparam int NBANK  = 4;
    localparam int NREG   = 4;
    localparam logic [1:0] REG_CAUSE = 2'd0;
    localparam logic [1:0] REG_SEL   = 2'd1;
    localparam logic [1:0] REG_HI    = 2'd2;
    localparam logic [1:0] REG_LO    = 2'd3;
    localparam logic [DW-1:0] BANK_MASK = 32'h0000_0003;

    function automatic logic is_mmu_bank(input logic [1:0] b);
        return (b == 2'd1) || (b == 2'd2);
    endfunction
endpackage

// File: rtl/tlbf_entry_store.sv
module tlbf_entry_store #(
    parameter int DW       = 32,
    parameter int NMMU     = 2,
    parameter int IDX_BITS = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wr_bank,
    input  logic [IDX_BITS-1:0] wr_idx,
    input  logic [DW-1:0]       wr_hi,
    input  logic [DW-1:0]       wr_lo,
    input  logic                rd_bank,
    input  logic [IDX_BITS-1:0] rd_idx,
    output logic [DW-1:0]       rd_hi,
    output logic [DW-1:0]       rd_lo
);
    localparam int ENTRIES = 1 << IDX_BITS;
    localparam int EW      = 2 * DW;

    logic [NMMU-1:0][EW-1:0] bank_rd;

    for (genvar g = 0; g < NMMU; g++) begin : g_bank
        logic [ENTRIES-1:0][EW-1:0] mem_d, mem_q;
        logic hit;

        always_comb begin
            hit   = wr_en && (int'(wr_bank) == g);
            mem_d = mem_q;
            if (hit) begin
                mem_d[wr_idx] = {wr_hi, wr_lo};
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q <= '0;
            end else begin
                mem_q <= mem_d;
            end
        end

        assign bank_rd[g] = mem_q[rd_idx];

        // R4: a commit lands in the addressed slot of this bank only
        p_commit_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(wr_bank) == g) |=>
                mem_q[$past(wr_idx)] == {$past(wr_hi), $past(wr_lo)});
    end

    assign rd_hi = bank_rd[rd_bank][EW-1:DW];
    assign rd_lo = bank_rd[rd_bank][DW-1:0];
endmodule

// File: rtl/tlbf_regbank.sv
module tlbf_regbank
    import tlbf_pkg::*;
#(
    parameter int PAGE_BITS = 12,
    parameter int IDX_BITS  = 6,
    parameter int VALID_BIT = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DW-1:0]       bank_sel,
    input  logic                acc_en,
    input  logic                acc_we,
    input  logic [1:0]          acc_reg,
    input  logic [DW-1:0]       acc_wdata,
    input  logic [DW-1:0]       ent_hi,
    input  logic [DW-1:0]       ent_lo,
    output logic                ent_bank,
    output logic [IDX_BITS-1:0] ent_idx,
    output logic                commit_we,
    output logic [DW-1:0]       commit_hi,
    output logic [DW-1:0]       commit_lo,
    output logic [DW-1:0]       acc_rdata,
    output logic                flush_valid,
    output logic [DW-1:0]       flush_addr,
    output logic                flush_old_valid
);
    localparam logic [DW-1:0] PAGE_MASK = ~((DW'(1) << PAGE_BITS) - DW'(1));

    typedef struct packed {
        logic [NBANK-1:0][NREG-1:0][DW-1:0] regs;
        logic [DW-1:0]                      rdata;
        logic                               fl_v;
        logic [DW-1:0]                      fl_addr;
        logic                               fl_ov;
    } state_t;

    state_t     st_d, st_q;
    logic [1:0] bk;
    logic       mmu;

    always_comb begin
        bk        = 2'(bank_sel & BANK_MASK);
        mmu       = is_mmu_bank(bk);
        ent_bank  = bk[1];
        ent_idx   = st_q.regs[bk][REG_SEL][IDX_BITS-1:0];
        commit_we = acc_en && acc_we && mmu && (acc_reg == REG_LO);
        commit_hi = st_q.regs[bk][REG_CAUSE];
        commit_lo = acc_wdata;

        st_d      = st_q;
        st_d.fl_v = 1'b0;
        if (acc_en) begin
            if (acc_we) begin
                st_d.regs[bk][acc_reg] = acc_wdata;
                if (mmu && acc_reg == REG_HI) begin
                    st_d.regs[bk][REG_CAUSE] = acc_wdata;
                end
                if (commit_we) begin
                    st_d.fl_v    = 1'b1;
                    st_d.fl_addr = ent_hi & PAGE_MASK;
                    st_d.fl_ov   = ent_lo[VALID_BIT];
                end
            end else if (mmu) begin
                st_d.regs[bk][REG_HI] = ent_hi;
                st_d.regs[bk][REG_LO] = ent_lo;
                case (acc_reg)
                    REG_HI:  st_d.rdata = ent_hi;
                    REG_LO:  st_d.rdata = ent_lo;
                    default: st_d.rdata = st_q.regs[bk][acc_reg];
                endcase
            end else begin
                st_d.rdata = st_q.regs[bk][acc_reg];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_rdata       = st_q.rdata;
    assign flush_valid     = st_q.fl_v;
    assign flush_addr      = st_q.fl_addr;
    assign flush_old_valid = st_q.fl_ov;

    // R3: HI write in an MMU bank leaves the cause register equal to the data
    p_hi_loads_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_we && mmu && acc_reg == REG_HI) |=>
            st_q.regs[$past(bk)][REG_CAUSE] == $past(acc_wdata));

    // R6: a flush pulse only ever follows an LO write in an MMU bank
    p_flush_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> $past(acc_en && acc_we && acc_reg == REG_LO && mmu));

    // R8: plain banks never raise a flush
    p_plain_noflush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_we && !mmu) |=> !flush_valid);

    // R10: reads never raise a flush
    p_read_noflush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_we) |=> !flush_valid);

    // R9: read data is stable unless a read was requested
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_en && !acc_we) |=> $stable(acc_rdata));
endmodule

// File: rtl/tlbf_front.sv
module tlbf_front #(
    parameter int PAGE_BITS = 12,
    parameter int SET_BITS  = 2,
    parameter int WAY_BITS  = 4,
    parameter int VALID_BIT = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] bank_sel,
    input  logic        acc_en,
    input  logic        acc_we,
    input  logic [1:0]  acc_reg,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    output logic        flush_valid,
    output logic [31:0] flush_addr,
    output logic        flush_old_valid
);
    localparam int IDX_BITS = SET_BITS + WAY_BITS;
    localparam int DW       = tlbf_pkg::DW;

    logic                ent_bank;
    logic [IDX_BITS-1:0] ent_idx;
    logic [DW-1:0]       ent_hi, ent_lo;
    logic                commit_we;
    logic [DW-1:0]       commit_hi, commit_lo;

    tlbf_regbank #(
        .PAGE_BITS (PAGE_BITS),
        .IDX_BITS  (IDX_BITS),
        .VALID_BIT (VALID_BIT)
    ) u_regs (
        .clk             (clk),
        .rst_n           (rst_n),
        .bank_sel        (bank_sel),
        .acc_en          (acc_en),
        .acc_we          (acc_we),
        .acc_reg         (acc_reg),
        .acc_wdata       (acc_wdata),
        .ent_hi          (ent_hi),
        .ent_lo          (ent_lo),
        .ent_bank        (ent_bank),
        .ent_idx         (ent_idx),
        .commit_we       (commit_we),
        .commit_hi       (commit_hi),
        .commit_lo       (commit_lo),
        .acc_rdata       (acc_rdata),
        .flush_valid     (flush_valid),
        .flush_addr      (flush_addr),
        .flush_old_valid (flush_old_valid)
    );

    tlbf_entry_store #(
        .DW       (DW),
        .NMMU     (2),
        .IDX_BITS (IDX_BITS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit_we),
        .wr_bank (ent_bank),
        .wr_idx  (ent_idx),
        .wr_hi   (commit_hi),
        .wr_lo   (commit_lo),
        .rd_bank (ent_bank),
        .rd_idx  (ent_idx),
        .rd_hi   (ent_hi),
        .rd_lo   (ent_lo)
    );
endmodule

// File: tb/sim_tlbf_front.sv
module sim_tlbf_front;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bank_sel = '0;
    logic        acc_en = 1'b0;
    logic        acc_we = 1'b0;
    logic [1:0]  acc_reg = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        flush_valid;
    logic [31:0] flush_addr;
    logic        flush_old_valid;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlbf_front u0 (
        .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .acc_en(acc_en),
        .acc_we(acc_we), .acc_reg(acc_reg), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .flush_valid(flush_valid),
        .flush_addr(flush_addr), .flush_old_valid(flush_old_valid)
    );

    typedef struct packed {
        logic [31:0] bsel;
        logic        we;
        logic [1:0]  rg;
        logic [31:0] wd;
        logic        chk;
        logic [31:0] exp_rd;
        logic        fl;
        logic [31:0] fa;
        logic        fv;
        logic [7:0]  req;
    } vec_t;

    // register codes: 0 cause, 1 select, 2 HI, 3 LO
    localparam int NV = 30;
    localparam vec_t VEC [NV] = '{
        '{32'h1, 1'b1, 2'd1, 32'h15,       1'b0, 32'h0,        1'b0, 32'h0,        1'b0, 8'd10}, // R10 select write
        '{32'h1, 1'b1, 2'd2, 32'hABCDE123, 1'b0, 32'h0,        1'b0, 32'h0,        1'b0, 8'd3},  // R3 HI write
        '{32'h1, 1'b0, 2'd0, 32'h0,        1'b1, 32'hABCDE123, 1'b0, 32'h0,        1'b0, 8'd3},  // R3 cause follows HI
        '{32'h1, 1'b1, 2'd3, 32'h00000F01, 1'b0, 32'h0,        1'b1, 32'h0,        1'b0, 8'd6},  // R6 commit over empty slot
        '{32'h1, 1'b0, 2'd2, 32'h0,        1'b1, 32'hABCDE123, 1'b0, 32'h0,        1'b0, 8'd4},  // R4 HI from cause
        '{32'h1, 1'b0, 2'd3, 32'h0,        1'b1, 32'h00000F01, 1'b0, 32'h0,        1'b0, 8'd4},  // R4 LO stored
        '{32'h1, 1'b1, 2'd2, 32'h12345678, 1'b0, 32'h0,        1'b0, 32'h0,        1'b0, 8'd10}, // R10 HI write no flush
        '{32'h1, 1'b1, 2'd3, 32'h00000002, 1'b0, 32'h0,        1'b1, 32'hABCDE000, 1'b1, 8'd6},  // R6 old page, valid
        '{32'h1, 1'b0, 2'd2, 32'h0,        1'b1, 32'h12345678, 1'b0, 32'h0,        1'b0, 8'd5},  // R5
        '{32'h5, 1'b0, 2'd3, 32'h0,        1'b1, 32'h00000002, 1'b0, 32'h0,        1'b0, 8'd2},  // R2 5 -> bank 1
        '{32'h2, 1'b0, 2'd2, 32'h0,        1'b1, 32'h0,        1'b0, 32'h0,        1'b0, 8'd7},  // R7
        '{32'h2, 1'b1, 2'd1, 32'h15,       1'b0, 32'h0,        1'b0, 32'h0,        1'b0, 8'd7},  // R7
        '{32'h2, 1'b0, 2'd2, 32'h0,        1'b1, 32'h0,        1'b0, 32'h0,        1'b0, 8'd7},  // R7 separate store
        '{32'h2, 1'b1, 2'd0, 32'h77777ABC, 1'b0, 32'h0,        1'b0, 32'h0,        1'b0, 8'd10}, // R10 cause write
        '{32'h2, 1'b1, 2'd3, 32'h00000001, 1'b0, 32'h0,        1'b1, 32'h0,        1'b0, 8'd6},  // R6
        '{32'h2, 1'b0, 2'd2, 32'h0,        1'b1, 32'h77777ABC, 1'b0, 32'h0,        1'b0, 8'd4},  // R4 HI from cause
        '{32'h2, 1'b1, 2'd3, 32'h00000003, 1'b0, 32'h0,        1'b1, 32'h77777000, 1'b1, 8'd6},  // R6
        '{32'h0, 1'b1, 2'd2, 32'hDEADBEEF, 1'b0, 32'h0,        1'b0, 32'h0,        1'b0, 8'd8},  // R8
        '{32'h0, 1'b1, 2'd3, 32'h00000055, 1'b0, 32'h0,        1'b0, 32'h0,        1'b0, 8'd8},  // R8 no commit
        '{32'h0, 1'b0, 2'd2, 32'h0,        1'b1, 32'hDEADBEEF, 1'b0, 32'h0,        1'b0, 8'd8},  // R8
        '{32'h0, 1'b0, 2'd0, 32'h0,        1'b1, 32'h0,        1'b0, 32'h0,        1'b0, 8'd8},  // R8 cause untouched
        '{32'h0, 1'b0, 2'd3, 32'h0,        1'b1, 32'h00000055, 1'b0, 32'h0,        1'b0, 8'd8},  // R8
        '{32'h1, 1'b0, 2'd2, 32'h0,        1'b1, 32'h12345678, 1'b0, 32'h0,        1'b0, 8'd8},  // R8 bank 1 intact
        '{32'h1, 1'b0, 2'd1, 32'h0,        1'b1, 32'h15,       1'b0, 32'h0,        1'b0, 8'd4},  // R4 select readback
        '{32'h7, 1'b1, 2'd2, 32'hCAFEF00D, 1'b0, 32'h0,        1'b0, 32'h0,        1'b0, 8'd2},  // R2 7 -> bank 3
        '{32'h3, 1'b0, 2'd2, 32'h0,        1'b1, 32'hCAFEF00D, 1'b0, 32'h0,        1'b0, 8'd2},  // R2
        '{32'h1, 1'b1, 2'd1, 32'h25,       1'b0, 32'h0,        1'b0, 32'h0,        1'b0, 8'd4},  // R4 other set
        '{32'h1, 1'b0, 2'd2, 32'h0,        1'b1, 32'h0,        1'b0, 32'h0,        1'b0, 8'd4},  // R4
        '{32'h1, 1'b1, 2'd1, 32'h05,       1'b0, 32'h0,        1'b0, 32'h0,        1'b0, 8'd4},  // R4 set 0
        '{32'h1, 1'b0, 2'd3, 32'h0,        1'b1, 32'h0,        1'b0, 32'h0,        1'b0, 8'd4}   // R4
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] b, input logic we, input logic [1:0] rg,
                          input logic [31:0] wd);
        bank_sel  = b;
        acc_en    = 1'b1;
        acc_we    = we;
        acc_reg   = rg;
        acc_wdata = wd;
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 rdata", acc_rdata, 32'h0);
        check("R1 flush", 32'(flush_valid), 32'h0);
        access(32'h1, 1'b0, 2'd1, 32'h0);
        check("R1 select", acc_rdata, 32'h0);
        access(32'h2, 1'b0, 2'd3, 32'h0);
        check("R1 entry", acc_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i].bsel, VEC[i].we, VEC[i].rg, VEC[i].wd);
            if (VEC[i].chk)
                check($sformatf("R%0d rdata v%0d", VEC[i].req, i), acc_rdata, VEC[i].exp_rd);
            check($sformatf("R%0d flush v%0d", VEC[i].req, i), 32'(flush_valid), 32'(VEC[i].fl));
            if (VEC[i].fl) begin
                check($sformatf("R%0d addr v%0d", VEC[i].req, i), flush_addr, VEC[i].fa);
                check($sformatf("R%0d oldv v%0d", VEC[i].req, i), 32'(flush_old_valid), 32'(VEC[i].fv));
            end
        end

        // R9: read data holds across writes and idle cycles
        access(32'h1, 1'b0, 2'd1, 32'h0);
        check("R9 read", acc_rdata, 32'h05);
        access(32'h0, 1'b1, 2'd1, 32'h99);
        check("R9 hold after write", acc_rdata, 32'h05);
        @(negedge clk);
        check("R9 hold idle", acc_rdata, 32'h05);

        // R6: pulse lasts one cycle only
        access(32'h1, 1'b1, 2'd3, 32'h7);
        check("R6 pulse", 32'(flush_valid), 32'h1);
        @(negedge clk);
        check("R6 pulse ends", 32'(flush_valid), 32'h0);
        check("R10 idle no flush", 32'(flush_valid), 32'h0);

        // R1: reset clears stored entries
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        access(32'h1, 1'b1, 2'd1, 32'h15);
        access(32'h1, 1'b0, 2'd2, 32'h0);
        check("R1 entry cleared", acc_rdata, 32'h0);
        access(32'h0, 1'b0, 2'd2, 32'h0);
        check("R1 plain cleared", acc_rdata, 32'h0);

        finish_run();
    end
endmodule